// File: doc/BRIEF.md
# Reference-Locked Clock Divider with Phase Select

This block derives a slow output clock from a fast sampling clock by counting sampling-clock cycles in a 2-bit phase counter. When it stands alone (master), the counter runs freely from its reset value, so the output clock phase is fixed only by reset. When it follows another divider (slave), it watches a reference clock that arrives from elsewhere. It brings that signal into the sampling-clock domain and reloads its phase counter on every reference rising edge. The reload value is a programmable quarter-period offset.

Each reference edge realigns the counter, so a slave that drifts or gets corrupted returns to the right phase on the next reference edge, with no separate reset pulse. If the reference stops, the slave holds its outputs low instead of running on with an unknown phase. The divided clock is also driven onto two reference outputs that always run at one quarter of the sampling rate, so that further dividers can be chained from this one. One disable bit gates both outputs together.

Top module: `refsync_clkdiv`

## Requirements
- R1: While reset is asserted and right after it, `div_clk`, `ref_out_a` and `ref_out_b` are low, the phase counter is 0, and the reference counts as lost.
- R2: With `slave_en`=0 and `half_rate`=0, the counter advances by one (mod 4) on every sampling edge and `div_clk` equals counter bit 1. After reset the output sequence is 0,1,1,0 repeating.
- R3: With `half_rate`=1, `div_clk` equals counter bit 0, so it toggles on every sampling edge unless it is held low by R8.
- R4: `ref_out_a` and `ref_out_b` always carry the same value, counter bit 1 (sampling rate / 4, 50% duty), whatever `half_rate` is. Once `out_disable`=1 has been sampled on an edge, both are low from that edge on.
- R5: `ref_in` passes through a two-flop synchronizer. A rising edge of `ref_in` first sampled high on edge k produces a counter load on edge k+2.
- R6: In slave mode the load sets the counter to the `phase_sel` value (00, 01, 10 or 11). Each code step moves the divided clock by one sampling cycle, which is a quarter period at divide-by-4.
- R7: With `slave_en`=0, activity on `ref_in` has no effect on any output.
- R8: If 16 sampling edges pass without a synchronized reference rising edge, the reference counts as lost. In slave mode all three outputs are then held low, and they resume on the edge that performs the next load.
- R9: The load repeats on every reference rising edge. A new `phase_sel` value or a disturbed counter is corrected at the next reference edge.
- R10: One reference rising edge produces exactly one single-cycle load strobe, however long the reference stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_en | input | 1 | 1 = follow the reference (slave), 0 = free-running (master) |
| phase_sel | input | 2 | Counter load value on a reference edge (quarter-period steps) |
| half_rate | input | 1 | 1 = divide-by-2 output, 0 = divide-by-4 output |
| out_disable | input | 1 | 1 = both reference outputs held low |
| ref_in | input | 1 | Incoming reference clock, asynchronous to `clk` |
| div_clk | output | 1 | Divided output clock |
| ref_out_a | output | 1 | Reference output for downstream dividers |
| ref_out_b | output | 1 | Second reference output, identical to `ref_out_a` |

## Verification
On every cycle the assertions check that the two reference outputs match, that the disable bit silences them, that the load strobe is a single-cycle pulse, that the slave holds its outputs low once its own count of strobe-free cycles reaches the loss limit, that a divide-by-4 load shows the selected phase at the output, and that free-running divide-by-2 toggles. The exact alignment after the synchronizer latency, the phase for each code, realignment after a phase change, recovery after reference loss and the insensitivity of master mode to the reference are only shown by the bench. Its behavioural model is compared with all outputs on every clock across these scenarios.

// File: rtl/refsync_pkg.sv
package refsync_pkg;
  localparam int PH_W = 2;
  typedef logic [PH_W-1:0] ph_t;

  function automatic logic rate_bit(input ph_t c, input logic half);
    return half ? c[0] : c[PH_W-1];
  endfunction
endpackage

// File: rtl/refsync_edge.sv
module refsync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic strobe
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= ref_in;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  // rising edge on the synchronized level (R5, R10)
  assign strobe = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/refsync_watch.sv
module refsync_watch #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic lost_nxt
);
  localparam int MW = $clog2(LIMIT + 1);
  localparam logic [MW-1:0] LIM = MW'(LIMIT);

  logic [MW-1:0] miss_q, miss_nxt;

  always_comb begin
    if (strobe)           miss_nxt = '0;
    else if (miss_q < LIM) miss_nxt = miss_q + 1'b1;
    else                  miss_nxt = miss_q;
  end

  assign lost_nxt = (miss_nxt >= LIM);

  // reset counts as lost (R1, R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) miss_q <= LIM;
    else        miss_q <= miss_nxt;
  end
endmodule

// File: rtl/refsync_phase_ctr.sv
module refsync_phase_ctr
  import refsync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic slave_en,
  input  logic strobe,
  input  ph_t  phase_sel,
  output ph_t  cnt_nxt
);
  ph_t cnt_q;

  // load on reference edge in slave mode (R6, R9), else free count (R2, R7)
  always_comb begin
    if (slave_en && strobe) cnt_nxt = phase_sel;
    else                    cnt_nxt = ph_t'(cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/refsync_clkdiv.sv
module refsync_clkdiv
  import refsync_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOSS_LIMIT  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slave_en,
  input  logic [1:0] phase_sel,
  input  logic       half_rate,
  input  logic       out_disable,
  input  logic       ref_in,
  output logic       div_clk,
  output logic       ref_out_a,
  output logic       ref_out_b
);
  logic strobe;
  logic lost_nxt;
  ph_t  cnt_nxt;
  logic hold;
  logic div_d, ref_d;

  refsync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .strobe(strobe)
  );

  refsync_watch #(.LIMIT(LOSS_LIMIT)) u_watch (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .lost_nxt(lost_nxt)
  );

  refsync_phase_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .strobe(strobe),
    .phase_sel(phase_sel), .cnt_nxt(cnt_nxt)
  );

  assign hold  = slave_en & lost_nxt;                          // R8
  assign div_d = hold ? 1'b0 : rate_bit(cnt_nxt, half_rate);   // R2, R3
  assign ref_d = (hold | out_disable) ? 1'b0 : cnt_nxt[PH_W-1]; // R4

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_clk   <= 1'b0;
      ref_out_a <= 1'b0;
      ref_out_b <= 1'b0;
    end else begin
      div_clk   <= div_d;
      ref_out_a <= ref_d;
      ref_out_b <= ref_d;
    end
  end
endmodule

// File: rtl/refsync_clkdiv_chk.sv
module refsync_clkdiv_chk #(
  parameter int LIMIT = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       slave_en,
  input logic [1:0] phase_sel,
  input logic       half_rate,
  input logic       out_disable,
  input logic       strobe,
  input logic       div_clk,
  input logic       ref_out_a,
  input logic       ref_out_b
);
  localparam int GW = $clog2(LIMIT + 1);
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gap <= GW'(LIMIT);
    else if (strobe)             gap <= '0;
    else if (gap < GW'(LIMIT))   gap <= gap + 1'b1;
  end

  AST_REF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ref_out_a == ref_out_b); // R4
  AST_DISABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    out_disable |=> (!ref_out_a && !ref_out_b)); // R4
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe); // R10
  AST_LOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_en && (gap >= GW'(LIMIT - 1)) && !strobe) |=> (!div_clk && !ref_out_a)); // R8
  AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_en && strobe && !half_rate) |=> (div_clk == $past(phase_sel[1]))); // R6
  AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_en && half_rate && $past(!slave_en) && $past(half_rate))
      |=> (div_clk != $past(div_clk))); // R3
endmodule

bind refsync_clkdiv refsync_clkdiv_chk #(.LIMIT(LOSS_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .phase_sel(phase_sel),
  .half_rate(half_rate), .out_disable(out_disable), .strobe(strobe),
  .div_clk(div_clk), .ref_out_a(ref_out_a), .ref_out_b(ref_out_b)
);

// File: tb/refsync_clkdiv_test.sv
module refsync_clkdiv_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, slave_en = 1'b0, half_rate = 1'b0, out_disable = 1'b1;
  logic ref_in = 1'b0;
  logic [1:0] phase_sel = 2'b00;
  logic div_clk, ref_out_a, ref_out_b;

  refsync_clkdiv uut (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .phase_sel(phase_sel),
    .half_rate(half_rate), .out_disable(out_disable), .ref_in(ref_in),
    .div_clk(div_clk), .ref_out_a(ref_out_a), .ref_out_b(ref_out_b)
  );

  int n_run = 0, n_fail = 0;
  string tag = "R1";
  bit chk_on = 0;
  int ref_period = 0, ref_tick = 0;

  // behavioural model
  bit   hist[$] = '{0, 0, 0};
  int   m_cnt = 0, m_miss = 16;
  logic m_div = 1'b0, m_ref = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_cnt = 0; m_miss = 16; m_div = 1'b0; m_ref = 1'b0;
    end else begin
      bit rise, gate;
      hist.push_back(ref_in);
      rise = hist[hist.size()-3] && !hist[hist.size()-4];
      if (hist.size() > 8) void'(hist.pop_front());
      if (slave_en && rise) m_cnt = phase_sel;
      else m_cnt = (m_cnt + 1) % 4;
      if (rise) m_miss = 0;
      else if (m_miss < 16) m_miss++;
      gate  = slave_en && (m_miss >= 16);
      m_div = gate ? 1'b0 : (half_rate ? ((m_cnt % 2) == 1) : (m_cnt >= 2));
      m_ref = (gate || out_disable) ? 1'b0 : (m_cnt >= 2);
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      n_run++;
      if (div_clk !== m_div || ref_out_a !== m_ref || ref_out_b !== m_ref) begin
        n_fail++;
        $display("FAIL %s: div/refa/refb = %b%b%b expected %b%b%b",
                 tag, div_clk, ref_out_a, ref_out_b, m_div, m_ref, m_ref);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) begin
      @(negedge clk); #1;
      if (ref_period > 0) begin
        ref_tick++;
        ref_in = (ref_tick % ref_period) < (ref_period / 2);
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cycles(3);
    // R1: outputs low during reset
    n_run++;
    if (div_clk !== 1'b0 || ref_out_a !== 1'b0 || ref_out_b !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: reset outputs %b%b%b expected 000", div_clk, ref_out_a, ref_out_b);
    end
    rst_n = 1'b1; chk_on = 1;
    tag = "R1"; cycles(2);
    tag = "R2"; out_disable = 1'b0; cycles(16);
    tag = "R7"; ref_period = 6; cycles(20);
    tag = "R3"; half_rate = 1'b1; cycles(12); half_rate = 1'b0;
    tag = "R4"; out_disable = 1'b1; cycles(8); out_disable = 1'b0; cycles(4);
    tag = "R6"; slave_en = 1'b1; ref_period = 4;
    for (int ph = 0; ph < 4; ph++) begin
      phase_sel = 2'(ph);
      cycles(16);
    end
    tag = "R5"; ref_period = 8; cycles(24);
    tag = "R9"; ref_period = 4; phase_sel = 2'd1; cycles(10);
    phase_sel = 2'd3; cycles(10);
    tag = "R10"; ref_period = 16; cycles(40);
    tag = "R8"; ref_period = 0; cycles(30);
    ref_period = 4; cycles(16);
    tag = "R3"; half_rate = 1'b1; phase_sel = 2'd1; cycles(16);
    // reset straight into slave mode with a silent reference
    chk_on = 0; rst_n = 1'b0; ref_period = 0; ref_in = 1'b0; half_rate = 1'b0;
    cycles(2);
    rst_n = 1'b1; chk_on = 1;
    tag = "R8"; cycles(20);
    tag = "R8"; ref_period = 4; cycles(12);
    chk_on = 0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule